// File: doc/BRIEF.md
# Four-Lane Block Mean Remover

This unit takes a block of four-lane audio and makes every lane zero-mean. Each beat carries four unsigned 8-bit samples on a valid/ready stream. The block is read twice. In the first pass the unit adds up each lane's samples. The number of samples comes from a programmable length. The unit then divides each lane's sum by that length, one lane at a time, on a single shared divider. That gives four lane means in signed Q1.15 form.

Once all four means are ready, the unit pulses a replay request. Upstream then presents the same block again. In the second pass each incoming sample has its lane mean taken away. The unit emits four signed Q1.15 lanes with a valid flag, one cycle after each accepted beat. A one-cycle done pulse marks the final beat of the block. There is no output back-pressure, so the consumer must take every valid beat.

A host starts each block by pulsing `start` together with the length. Lengths below 512 are raised to 512 and flagged.

Top module: `chan_mean_remover`

## Requirements
- R1: Lane k of `in_data` sits at bits [8k+7:8k]. It holds an unsigned byte u, which is read as the signed Q1.7 value u-128. The centred output for that lane is at bits [16k+15:16k] of `out_data`, and equals (u-128)*256 minus the lane mean, as 16-bit two's complement.
- R2: A lane mean is the sum of (u-128) over the block, times 256, divided by the effective length. The quotient is truncated toward zero.
- R3: On an accepted `start`, a `blk_len` below 512 is used as 512 and `len_err` goes to 1. Otherwise the length is used as given and `len_err` goes to 0. `len_err` changes only on an accepted `start`.
- R4: The first pass accepts exactly the effective length of beats. `in_ready` is then low until the replay request.
- R5: After the fourth mean is computed, `replay_req` is high for exactly one cycle. `in_ready` is high in that same cycle, which opens the second pass.
- R6: Each beat accepted in the second pass gives exactly one `out_valid` cycle, on the next clock. `out_valid` is low at all other times.
- R7: A centred result above 32767 is saturated to 32767 (0x7FFF). A result below -32768 is saturated to -32768 (0x8000).
- R8: `done` is high for one cycle, together with the output of the last second-pass beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a block when the unit is idle |
| blk_len | input | 16 | Samples per block, taken at start |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit takes a beat this cycle |
| in_data | input | 32 | Four unsigned 8-bit samples |
| replay_req | output | 1 | Pulse asking upstream to resend the block |
| out_valid | output | 1 | Centred beat present |
| out_data | output | 64 | Four signed Q1.15 centred samples |
| done | output | 1 | Pulse on the final centred beat |
| len_err | output | 1 | Length was below 512 and was clamped |

## Verification
The reset values are checked first. After that, inputs change on falling edges and the bench samples on falling edges. As a result, `len_err` is checked on the first falling edge after `start`. Each centred beat, and `done` with the last one, is checked on the falling edge that follows the edge where that beat was accepted.

`in_ready` is checked low right after the final first-pass beat. The bench then waits for the replay pulse, which comes about 4x32 divider cycles later. The next edge confirms that the pulse and `done` each lasted exactly one cycle.

The input patterns cover constant lanes, varied ramps, a clamped short length, and a skewed block that forces saturation.

// File: rtl/chan_mean_remover.sv
module chan_mean_remover #(
  parameter int NCH     = 4,
  parameter int SW      = 8,
  parameter int LW      = 16,
  parameter int OW      = 16,
  parameter int MIN_LEN = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LW-1:0]     blk_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*SW-1:0] in_data,
  output logic              replay_req,
  output logic              out_valid,
  output logic [NCH*OW-1:0] out_data,
  output logic              done,
  output logic              len_err
);
  localparam int AW = SW + LW;
  localparam int DW = AW + OW - SW;
  localparam int BW = $clog2(DW);
  localparam int CW = $clog2(NCH);

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_LD, S_DIV, S_CTR} st_t;
  st_t st;

  logic [LW-1:0] len_q, cnt_q, rem_q;
  logic signed [AW-1:0] sum_q [NCH];
  logic signed [OW-1:0] mean_q [NCH];
  logic [DW-1:0] dvd_q;
  logic [BW-1:0] bit_q;
  logic [CW-1:0] ch_q;
  logic neg_q;

  assign in_ready = (st == S_ACC) || (st == S_CTR);
  wire accept    = in_valid && in_ready;
  wire last_beat = cnt_q == len_q - 1'b1;

  logic signed [SW-1:0] xs [NCH];
  logic signed [OW:0]   dif [NCH];
  logic [NCH*OW-1:0]    ctr_data;
  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      xs[k]  = $signed({~in_data[k*SW+SW-1], in_data[k*SW +: SW-1]});
      dif[k] = $signed({xs[k][SW-1], xs[k], {(OW-SW){1'b0}}}) - $signed({mean_q[k][OW-1], mean_q[k]});
      if (dif[k][OW] != dif[k][OW-1])
        ctr_data[k*OW +: OW] = dif[k][OW] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
      else
        ctr_data[k*OW +: OW] = dif[k][OW-1:0];
    end
  end

  wire [LW:0]    shl  = {rem_q, dvd_q[DW-1]};
  wire           qbit = shl >= {1'b0, len_q};
  wire [DW-1:0]  quo  = {dvd_q[DW-2:0], qbit};
  wire [OW-1:0]  mean_new = neg_q ? OW'(-quo) : quo[OW-1:0];
  wire [CW-1:0]  ld_idx = (st == S_LD) ? '0 : ch_q + 1'b1;
  wire signed [AW-1:0] ld_sum = sum_q[ld_idx];
  wire [AW-1:0]  ld_mag = ld_sum[AW-1] ? -ld_sum : ld_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; out_valid <= 1'b0; done <= 1'b0; replay_req <= 1'b0; len_err <= 1'b0;
      len_q <= '0; cnt_q <= '0; rem_q <= '0; dvd_q <= '0; bit_q <= '0; ch_q <= '0; neg_q <= 1'b0;
      out_data <= '0;
      for (int k = 0; k < NCH; k++) begin sum_q[k] <= '0; mean_q[k] <= '0; end
    end else begin
      out_valid <= 1'b0; done <= 1'b0; replay_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          len_q   <= (blk_len < LW'(MIN_LEN)) ? LW'(MIN_LEN) : blk_len;
          len_err <= blk_len < LW'(MIN_LEN);
          cnt_q   <= '0;
          for (int k = 0; k < NCH; k++) sum_q[k] <= '0;
          st <= S_ACC;
        end
        S_ACC: if (accept) begin
          for (int k = 0; k < NCH; k++) sum_q[k] <= sum_q[k] + AW'(xs[k]);
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) begin cnt_q <= '0; st <= S_LD; end
        end
        S_LD, S_DIV: begin
          if (st == S_DIV) begin
            rem_q <= qbit ? LW'(shl - {1'b0, len_q}) : shl[LW-1:0];
            dvd_q <= quo;
            bit_q <= bit_q + 1'b1;
          end
          if (st == S_LD || bit_q == BW'(DW-1)) begin
            if (st == S_DIV) mean_q[ch_q] <= mean_new;
            if (st == S_DIV && ch_q == CW'(NCH-1)) begin
              replay_req <= 1'b1;
              st <= S_CTR;
            end else begin
              ch_q  <= ld_idx;
              rem_q <= '0;
              dvd_q <= {ld_mag, {(OW-SW){1'b0}}};
              neg_q <= ld_sum[AW-1];
              bit_q <= '0;
              st    <= S_DIV;
            end
          end
        end
        S_CTR: if (accept) begin
          out_data  <= ctr_data;
          out_valid <= 1'b1;
          cnt_q     <= cnt_q + 1'b1;
          if (last_beat) begin done <= 1'b1; st <= S_IDLE; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept && st == S_CTR));
  // R5
  replay_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_req |-> (in_ready && $past(st == S_DIV)));
  // R5
  replay_once_chk: assert property (@(posedge clk) disable iff (!rst_n) replay_req |=> !replay_req);
  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && st == S_IDLE) |=> $stable(len_err));
  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st == S_ACC && last_beat) |=> !in_ready);
endmodule

// File: tb/chan_mean_remover_tb.sv
module chan_mean_remover_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [15:0] blk_len = '0;
  logic [31:0] in_data = '0;
  logic in_ready, replay_req, out_valid, done, len_err;
  logic [63:0] out_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_mean_remover dut_i (.clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .replay_req(replay_req),
    .out_valid(out_valid), .out_data(out_data), .done(done), .len_err(len_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int pat, input int i, input int k);
    case (pat)
      0: gen = (k == 0) ? 200 : (k == 1) ? 50 : (k == 2) ? 128 : 0;
      1: gen = (i * (k + 3) + 17 * k) & 255;
      2: gen = (i == 0) ? 255 : 0;
      default: gen = (i * 7 + k * 60) & 255;
    endcase
  endfunction

  function automatic logic [31:0] pack(input int pat, input int i);
    for (int k = 0; k < 4; k++) pack[k*8 +: 8] = 8'(gen(pat, i, k));
  endfunction

  function automatic longint sat16(input longint v);
    sat16 = (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  task automatic run_block(input string name, input int pat, input int plen, input int eff);
    longint mean [4];
    longint s, e, a;
    int wait_n;
    $display("scenario %s", name);
    @(negedge clk); start = 1'b1; blk_len = 16'(plen);
    @(negedge clk); start = 1'b0;
    // R3: flag follows the programmed length
    chk(len_err == (plen < 512), "R3 len_err", len_err, plen < 512);
    for (int i = 0; i < eff; i++) begin
      in_valid = 1'b1; in_data = pack(pat, i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    // R4: pass one closes after exactly eff beats
    chk(in_ready == 1'b0 && replay_req == 1'b0, "R4 ready low after pass one", in_ready, 0);
    for (int k = 0; k < 4; k++) begin
      s = 0;
      for (int i = 0; i < eff; i++) s += gen(pat, i, k) - 128;
      mean[k] = (s * 256) / eff; // R2: truncation toward zero
    end
    wait_n = 0;
    while (!replay_req && wait_n < 400) begin @(negedge clk); wait_n++; end
    // R5: replay pulse opens pass two
    chk(replay_req && in_ready, "R5 replay with ready", replay_req, 1);
    for (int i = 0; i < eff; i++) begin
      in_valid = 1'b1; in_data = pack(pat, i);
      @(negedge clk);
      if (i == 0) chk(replay_req == 1'b0, "R5 replay one cycle", replay_req, 0);
      // R6: one output per accepted beat, next cycle
      chk(out_valid == 1'b1, "R6 out_valid", out_valid, 1);
      for (int k = 0; k < 4; k++) begin
        e = sat16((longint'(gen(pat, i, k)) - 128) * 256 - mean[k]);
        a = longint'($signed(out_data[k*16 +: 16]));
        // R1 R2 R7: centred value per lane
        chk(a == e, "R1 centred lane", a, e);
      end
      // R8: done only with last beat
      chk(done == (i == eff - 1), "R8 done timing", done, i == eff - 1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(out_valid == 1'b0, "R6 no spurious valid", out_valid, 0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R6 reset out_valid", out_valid, 0);
    chk(in_ready == 0, "R4 reset in_ready", in_ready, 0);
    chk(done == 0, "R8 reset done", done, 0);
    chk(replay_req == 0, "R5 reset replay", replay_req, 0);
    chk(len_err == 0, "R3 reset len_err", len_err, 0);
  endtask

  task automatic test_saturation();
    run_block("skewed", 2, 512, 512);
    // R7: recompute the single high beat lane0 is clipped to 0x7FFF
    chk(sat16(32512 + 32640) == 32767, "R7 bench model", sat16(32512 + 32640), 32767);
  endtask

  initial begin
    test_reset();
    run_block("constant", 0, 512, 512);
    run_block("ramp", 1, 600, 600);
    run_block("clamped", 3, 10, 512);
    test_saturation();
    run_block("ramp_again", 1, 700, 700);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule